// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block produces the source and destination byte addresses for a single DMA channel whose transfer is split into frames, each holding a fixed number of elements. A load strobe captures both start addresses, the element and frame counts, a 2-bit element size code, one addressing mode per side and signed 16-bit element and frame offsets. From the cycle after the load, every step strobe moves both addresses on by one element and updates the element and frame counters. Each side applies its own per-element and per-frame increments.

A channel controller drives the strobes. It reads the two addresses to issue bus accesses and watches the busy, error and block-done outputs to sequence the channel. A load that carries a zero count is refused and reported. After the final element of the final frame the sequencer pulses block-done and stops until it is loaded again. In legacy-compatible mode, both sides take their offsets from the source-side offset inputs.

Top module: `dma2d_addr_seq`

## Requirements
- R1: The element size is 1, 2 or 4 bytes for size code 0, 1 or 2. Size code 3 is treated as 4 bytes.
- R2: In fixed mode (mode code 0), a side's address never changes after load.
- R3: In increment mode (mode code 1), each accepted step adds the element size to the address. A frame boundary adds nothing more.
- R4: In single-offset mode (mode code 2), each step adds size + element offset − 1, with the 16-bit offset sign-extended. A frame boundary adds nothing more.
- R5: In double-offset mode (mode code 3), each step adds size + element offset − 1. The step that completes a frame also adds frame offset − element offset, with both offsets signed.
- R6: When `legacy_i` is 1 at load, the destination side uses the source-side element and frame offsets. When it is 0, each side uses its own offsets.
- R7: The element counter rises by one per accepted step. On the step that brings it to the element count, it returns to 0 and the frame counter rises by one. Both counters, like all outputs, are registered and change on the clock edge that samples the strobe.
- R8: A load with an element count or frame count of zero sets `cfg_err_o`, clears `busy_o`, and leaves the addresses and counters unchanged. Later steps are ignored. The next valid load clears the error.
- R9: On the step where the frame counter reaches the frame count, `block_done_o` is high for exactly one cycle and `busy_o` falls. Further steps change neither the addresses nor the counters until the next load.
- R10: Address arithmetic is 32 bits and wraps modulo 2^32.
- R11: While `rst_n` is low, every output is zero.
- R12: A load in the same cycle as a step takes priority. The step is dropped and the new configuration starts from its start addresses with both counters at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| load_i | input | 1 | Capture configuration |
| step_i | input | 1 | Advance one element |
| src_start_i | input | 32 | Source start byte address |
| dst_start_i | input | 32 | Destination start byte address |
| elem_cnt_i | input | 16 | Elements per frame |
| frame_cnt_i | input | 16 | Frames per block |
| size_code_i | input | 2 | Element size code |
| src_mode_i | input | 2 | Source addressing mode |
| dst_mode_i | input | 2 | Destination addressing mode |
| src_eoff_i | input | 16 | Source signed element offset |
| src_foff_i | input | 16 | Source signed frame offset |
| dst_eoff_i | input | 16 | Destination signed element offset |
| dst_foff_i | input | 16 | Destination signed frame offset |
| legacy_i | input | 1 | Both sides use the source offsets |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |
| elem_ctr_o | output | 16 | Current element index within frame |
| frame_ctr_o | output | 16 | Completed frame count |
| busy_o | output | 1 | Sequencer accepts steps |
| cfg_err_o | output | 1 | Last load was refused |
| block_done_o | output | 1 | One-cycle block completion pulse |

## Verification
The bench runs each addressing mode on its own and in pairs. A fixed side paired with an incrementing side separates the per-side mode decode. Negative element and frame offsets in double-offset mode separate sign extension from zero extension, and separate the frame-boundary term from the element term. A legacy load with deliberately different destination offsets shows which offset set was used. Steps are issued in bursts with gaps, after completion and after a refused load, and in the same cycle as a load. Start addresses just below 2^32 exercise wrap-around.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INCR  = 2'd1,
    AM_OFF1  = 2'd2,
    AM_OFF2  = 2'd3
  } amode_e;

  localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/dma2d_step_calc.sv
module dma2d_step_calc
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic [1:0]        size_code_i,
  input  amode_e            mode_i,
  input  logic [IDX_W-1:0]  eoff_i,
  input  logic [IDX_W-1:0]  foff_i,
  output logic [ADDR_W-1:0] elem_step_o,
  output logic [ADDR_W-1:0] frame_step_o
);

  localparam int EXT_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] esz;
  logic [ADDR_W-1:0] eoff_x;
  logic [ADDR_W-1:0] foff_x;
  logic [ADDR_W-1:0] off_step;
  logic [1:0]        shamt;

  always_comb begin
    shamt    = (size_code_i == 2'd3) ? 2'd2 : size_code_i;
    esz      = {{(ADDR_W-1){1'b0}}, 1'b1} << shamt;
    eoff_x   = {{EXT_W{eoff_i[IDX_W-1]}}, eoff_i};
    foff_x   = {{EXT_W{foff_i[IDX_W-1]}}, foff_i};
    off_step = esz + eoff_x - {{(ADDR_W-1){1'b0}}, 1'b1};
    case (mode_i)
      AM_FIXED: begin
        elem_step_o  = '0;
        frame_step_o = '0;
      end
      AM_INCR: begin
        elem_step_o  = esz;
        frame_step_o = '0;
      end
      AM_OFF1: begin
        elem_step_o  = off_step;
        frame_step_o = '0;
      end
      default: begin
        elem_step_o  = off_step;
        frame_step_o = foff_x - eoff_x;
      end
    endcase
  end

  always_comb begin
    assert (elem_step_o != '0 || mode_i == AM_FIXED || mode_i == AM_OFF1 || mode_i == AM_OFF2)
      else $error("AST_INCR_NONZERO"); // R3
  end

endmodule

// File: rtl/dma2d_addr_side.sv
module dma2d_addr_side #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ok_i,
  input  logic              adv_i,
  input  logic              frame_wrap_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] elem_step_i,
  input  logic [ADDR_W-1:0] frame_step_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] es_q, es_d;
  logic [ADDR_W-1:0] fs_q, fs_d;
  logic              en;

  always_comb begin
    addr_d = addr_q;
    es_d   = es_q;
    fs_d   = fs_q;
    en     = load_ok_i | adv_i;
    if (load_ok_i) begin
      addr_d = start_i;
      es_d   = elem_step_i;
      fs_d   = frame_step_i;
    end else if (adv_i) begin
      addr_d = addr_q + es_q + (frame_wrap_i ? fs_q : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      es_q   <= '0;
      fs_q   <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      es_q   <= es_d;
      fs_q   <= fs_d;
    end
  end

  assign addr_o = addr_q;

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ok_i && !adv_i |=> $stable(addr_q)); // R9
  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok_i |=> addr_q == $past(start_i)); // R12

endmodule

// File: rtl/dma2d_frame_ctr.sv
module dma2d_frame_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] elem_cnt_i,
  input  logic [CNT_W-1:0] frame_cnt_i,
  output logic             load_ok_o,
  output logic             adv_o,
  output logic             frame_wrap_o,
  output logic [CNT_W-1:0] elem_ctr_o,
  output logic [CNT_W-1:0] frame_ctr_o,
  output logic             busy_o,
  output logic             err_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] elem_q, elem_d, frame_q, frame_d;
  logic [CNT_W-1:0] ecnt_q, ecnt_d, fcnt_q, fcnt_d;
  logic             busy_q, busy_d, err_q, err_d, done_q, done_d;
  logic             cfg_bad, elem_last, frame_last;

  always_comb begin
    cfg_bad      = (elem_cnt_i == '0) || (frame_cnt_i == '0);
    load_ok_o    = load_i && !cfg_bad;
    adv_o        = step_i && busy_q && !load_i;
    elem_last    = (elem_q == ecnt_q - ONE);
    frame_last   = (frame_q == fcnt_q - ONE);
    frame_wrap_o = adv_o && elem_last;

    elem_d  = elem_q;
    frame_d = frame_q;
    ecnt_d  = ecnt_q;
    fcnt_d  = fcnt_q;
    busy_d  = busy_q;
    err_d   = err_q;
    done_d  = 1'b0;

    if (load_i) begin
      if (cfg_bad) begin
        err_d  = 1'b1;
        busy_d = 1'b0;
      end else begin
        err_d   = 1'b0;
        busy_d  = 1'b1;
        elem_d  = '0;
        frame_d = '0;
        ecnt_d  = elem_cnt_i;
        fcnt_d  = frame_cnt_i;
      end
    end else if (adv_o) begin
      if (elem_last) begin
        elem_d  = '0;
        frame_d = frame_q + ONE;
        if (frame_last) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end else begin
        elem_d = elem_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q  <= '0;
      frame_q <= '0;
      ecnt_q  <= '0;
      fcnt_q  <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      elem_q  <= elem_d;
      frame_q <= frame_d;
      ecnt_q  <= ecnt_d;
      fcnt_q  <= fcnt_d;
      busy_q  <= busy_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign elem_ctr_o  = elem_q;
  assign frame_ctr_o = frame_q;
  assign busy_o      = busy_q;
  assign err_o       = err_q;
  assign done_o      = done_q;

  AST_ELEM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> elem_q < ecnt_q); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && frame_q == fcnt_q); // R9
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy_q); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && step_i && !cfg_bad |=> busy_q && elem_q == '0 && frame_q == '0); // R12
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !load_i |=> $stable(elem_q) && $stable(frame_q)); // R9

endmodule

// File: rtl/dma2d_addr_seq.sv
module dma2d_addr_seq
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] src_start_i,
  input  logic [ADDR_W-1:0] dst_start_i,
  input  logic [CNT_W-1:0]  elem_cnt_i,
  input  logic [CNT_W-1:0]  frame_cnt_i,
  input  logic [1:0]        size_code_i,
  input  logic [1:0]        src_mode_i,
  input  logic [1:0]        dst_mode_i,
  input  logic [IDX_W-1:0]  src_eoff_i,
  input  logic [IDX_W-1:0]  src_foff_i,
  input  logic [IDX_W-1:0]  dst_eoff_i,
  input  logic [IDX_W-1:0]  dst_foff_i,
  input  logic              legacy_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [CNT_W-1:0]  elem_ctr_o,
  output logic [CNT_W-1:0]  frame_ctr_o,
  output logic              busy_o,
  output logic              cfg_err_o,
  output logic              block_done_o
);

  logic [NUM_SIDES-1:0][ADDR_W-1:0] start_w, estep_w, fstep_w, addr_w;
  logic [NUM_SIDES-1:0][1:0]        mode_w;
  logic [NUM_SIDES-1:0][IDX_W-1:0]  eoff_w, foff_w;
  logic                             load_ok, adv, frame_wrap;

  always_comb begin
    start_w[0] = src_start_i;
    start_w[1] = dst_start_i;
    mode_w[0]  = src_mode_i;
    mode_w[1]  = dst_mode_i;
    eoff_w[0]  = src_eoff_i;
    foff_w[0]  = src_foff_i;
    eoff_w[1]  = legacy_i ? src_eoff_i : dst_eoff_i;
    foff_w[1]  = legacy_i ? src_foff_i : dst_foff_i;
  end

  dma2d_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .step_i       (step_i),
    .elem_cnt_i   (elem_cnt_i),
    .frame_cnt_i  (frame_cnt_i),
    .load_ok_o    (load_ok),
    .adv_o        (adv),
    .frame_wrap_o (frame_wrap),
    .elem_ctr_o   (elem_ctr_o),
    .frame_ctr_o  (frame_ctr_o),
    .busy_o       (busy_o),
    .err_o        (cfg_err_o),
    .done_o       (block_done_o)
  );

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    dma2d_step_calc #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_calc (
      .size_code_i  (size_code_i),
      .mode_i       (amode_e'(mode_w[g])),
      .eoff_i       (eoff_w[g]),
      .foff_i       (foff_w[g]),
      .elem_step_o  (estep_w[g]),
      .frame_step_o (fstep_w[g])
    );

    dma2d_addr_side #(.ADDR_W(ADDR_W)) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_ok_i    (load_ok),
      .adv_i        (adv),
      .frame_wrap_i (frame_wrap),
      .start_i      (start_w[g]),
      .elem_step_i  (estep_w[g]),
      .frame_step_i (fstep_w[g]),
      .addr_o       (addr_w[g])
    );
  end

  assign src_addr_o = addr_w[0];
  assign dst_addr_o = addr_w[1];

  AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o && !load_i |=> $stable(src_addr_o) && $stable(dst_addr_o)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    block_done_o |-> !busy_o && !cfg_err_o); // R9

endmodule

// File: tb/dma2d_addr_seq_tb.sv
module dma2d_addr_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0, step_i = 1'b0, legacy_i = 1'b0;
  logic [31:0] src_start_i = '0, dst_start_i = '0;
  logic [15:0] elem_cnt_i = '0, frame_cnt_i = '0;
  logic [1:0]  size_code_i = '0, src_mode_i = '0, dst_mode_i = '0;
  logic [15:0] src_eoff_i = '0, src_foff_i = '0, dst_eoff_i = '0, dst_foff_i = '0;
  logic [31:0] src_addr_o, dst_addr_o;
  logic [15:0] elem_ctr_o, frame_ctr_o;
  logic        busy_o, cfg_err_o, block_done_o;

  always #2 clk = ~clk;

  dma2d_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
    .src_start_i(src_start_i), .dst_start_i(dst_start_i),
    .elem_cnt_i(elem_cnt_i), .frame_cnt_i(frame_cnt_i),
    .size_code_i(size_code_i), .src_mode_i(src_mode_i), .dst_mode_i(dst_mode_i),
    .src_eoff_i(src_eoff_i), .src_foff_i(src_foff_i),
    .dst_eoff_i(dst_eoff_i), .dst_foff_i(dst_foff_i), .legacy_i(legacy_i),
    .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o),
    .elem_ctr_o(elem_ctr_o), .frame_ctr_o(frame_ctr_o),
    .busy_o(busy_o), .cfg_err_o(cfg_err_o), .block_done_o(block_done_o)
  );

  // reference model state
  logic [31:0] m_addr [2] = '{0, 0};
  logic [31:0] m_es [2] = '{0, 0};
  logic [31:0] m_fs [2] = '{0, 0};
  int          m_e = 0, m_f = 0, m_ecnt = 0, m_fcnt = 0;
  bit          m_busy = 0, m_err = 0, m_done = 0;

  int    vectors = 0, miscompares = 0;
  string cur_req = "R11";
  bit    running = 0;

  function automatic int size_bytes(input logic [1:0] c);
    if (c == 2'd0) return 1;
    if (c == 2'd1) return 2;
    return 4;
  endfunction

  function automatic void side_steps(input logic [1:0] md, input logic [15:0] eo, input logic [15:0] fo,
                                     input logic [1:0] c, output logic [31:0] es, output logic [31:0] fs);
    int sz = size_bytes(c);
    int e = int'($signed(eo));
    int f = int'($signed(fo));
    es = 0; fs = 0;
    if (md == 2'd1) es = sz;
    else if (md == 2'd2) es = sz + e - 1;
    else if (md == 2'd3) begin es = sz + e - 1; fs = f - e; end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr[0] = 0; m_addr[1] = 0; m_e = 0; m_f = 0;
      m_busy = 0; m_err = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (load_i) begin
        if (elem_cnt_i == 0 || frame_cnt_i == 0) begin
          m_err = 1; m_busy = 0;
        end else begin
          m_err = 0; m_busy = 1; m_e = 0; m_f = 0;
          m_ecnt = elem_cnt_i; m_fcnt = frame_cnt_i;
          m_addr[0] = src_start_i; m_addr[1] = dst_start_i;
          side_steps(src_mode_i, src_eoff_i, src_foff_i, size_code_i, m_es[0], m_fs[0]);
          if (legacy_i) side_steps(dst_mode_i, src_eoff_i, src_foff_i, size_code_i, m_es[1], m_fs[1]);
          else          side_steps(dst_mode_i, dst_eoff_i, dst_foff_i, size_code_i, m_es[1], m_fs[1]);
        end
      end else if (step_i && m_busy) begin
        for (int s = 0; s < 2; s++) m_addr[s] = m_addr[s] + m_es[s];
        m_e++;
        if (m_e == m_ecnt) begin
          m_e = 0;
          for (int s = 0; s < 2; s++) m_addr[s] = m_addr[s] + m_fs[s];
          m_f++;
          if (m_f == m_fcnt) begin m_busy = 0; m_done = 1; end
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (running) begin
      vectors++;
      if (src_addr_o !== m_addr[0] || dst_addr_o !== m_addr[1] ||
          elem_ctr_o !== 16'(m_e) || frame_ctr_o !== 16'(m_f) ||
          busy_o !== m_busy || cfg_err_o !== m_err || block_done_o !== m_done) begin
        miscompares++;
        $display("FAIL %s t=%0t actual src=%h dst=%h e=%0d f=%0d b=%b err=%b d=%b expected src=%h dst=%h e=%0d f=%0d b=%b err=%b d=%b",
          cur_req, $time, src_addr_o, dst_addr_o, elem_ctr_o, frame_ctr_o, busy_o, cfg_err_o, block_done_o,
          m_addr[0], m_addr[1], m_e, m_f, m_busy, m_err, m_done);
      end
    end
  end

  task automatic cfg_load(input logic [31:0] sa, input logic [31:0] da, input int ec, input int fc,
                          input logic [1:0] sz, input logic [1:0] sm, input logic [1:0] dm,
                          input logic [15:0] se, input logic [15:0] sf,
                          input logic [15:0] de, input logic [15:0] df, input bit lg, input bit with_step);
    @(negedge clk);
    src_start_i = sa; dst_start_i = da; elem_cnt_i = 16'(ec); frame_cnt_i = 16'(fc);
    size_code_i = sz; src_mode_i = sm; dst_mode_i = dm;
    src_eoff_i = se; src_foff_i = sf; dst_eoff_i = de; dst_foff_i = df; legacy_i = lg;
    load_i = 1; step_i = with_step;
    @(negedge clk);
    load_i = 0; step_i = 0;
  endtask

  task automatic steps(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); step_i = 1;
      @(negedge clk); step_i = 0;
      for (int k = 0; k < gap; k++) @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    running = 1;
    repeat (3) @(negedge clk);
    // R11: outputs held at zero during reset (also compared above)
    vectors++;
    if (src_addr_o !== 0 || dst_addr_o !== 0 || busy_o !== 0 || block_done_o !== 0 || cfg_err_o !== 0) begin
      miscompares++;
      $display("FAIL R11 reset actual src=%h busy=%b expected 0", src_addr_o, busy_o);
    end
    @(negedge clk); rst_n = 1;

    cur_req = "R3";  // increment source, fixed destination (R2), 4-byte
    cfg_load(32'h1000, 32'h8000, 3, 2, 2'd2, 2'd1, 2'd0, 0, 0, 0, 0, 0, 0);
    steps(6, 0);
    cur_req = "R9";  // steps after block end are ignored
    steps(3, 1);

    cur_req = "R4";
    cfg_load(32'h2000, 32'h3000, 4, 2, 2'd0, 2'd2, 2'd2, 16'd5, 16'd0, 16'hFFFD, 16'd0, 0, 0);
    steps(8, 2);

    cur_req = "R5";
    cfg_load(32'h4000, 32'h5000, 3, 3, 2'd1, 2'd3, 2'd3, 16'd2, 16'hFFEC, 16'hFFFF, 16'd100, 0, 0);
    steps(9, 1);

    cur_req = "R6";
    cfg_load(32'h6000, 32'h7000, 2, 2, 2'd1, 2'd3, 2'd3, 16'd3, 16'd40, 16'hFF00, 16'h0F00, 1, 0);
    steps(4, 0);
    cfg_load(32'h6000, 32'h7000, 2, 2, 2'd1, 2'd3, 2'd3, 16'd3, 16'd40, 16'hFF00, 16'h0F00, 0, 0);
    steps(4, 0);

    cur_req = "R8";
    cfg_load(32'hAAAA, 32'hBBBB, 0, 2, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0, 0, 0);
    steps(2, 0);
    cfg_load(32'hCCCC, 32'hDDDD, 3, 0, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0, 0, 0);
    steps(2, 0);
    cfg_load(32'h100, 32'h200, 2, 1, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0, 0, 0);
    steps(2, 0);

    cur_req = "R10";  // wrap, size code 3 counts as 4 bytes (R1)
    cfg_load(32'hFFFF_FFF8, 32'h0000_0002, 4, 1, 2'd3, 2'd1, 2'd2, 0, 0, 16'hFFF8, 0, 0, 0);
    steps(4, 0);

    cur_req = "R12";
    cfg_load(32'h9000, 32'h9100, 5, 2, 2'd0, 2'd1, 2'd1, 0, 0, 0, 0, 0, 0);
    steps(3, 0);
    cfg_load(32'h1234, 32'h5678, 2, 2, 2'd1, 2'd1, 2'd1, 0, 0, 0, 0, 0, 1);
    steps(4, 0);

    cur_req = "R1";
    cfg_load(32'h0, 32'h10, 3, 1, 2'd0, 2'd1, 2'd1, 0, 0, 0, 0, 0, 0);
    steps(3, 0);
    cfg_load(32'h0, 32'h10, 3, 1, 2'd1, 2'd1, 2'd1, 0, 0, 0, 0, 0, 0);
    steps(3, 0);

    cur_req = "R7";  // counters with irregular gaps
    cfg_load(32'h40, 32'h80, 3, 3, 2'd2, 2'd1, 2'd3, 0, 0, 16'd4, 16'hFFF0, 0, 0);
    steps(9, 3);

    repeat (3) @(negedge clk);
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule